// File: doc/BRIEF.md
# Variable-Count Bit Packer

This block sits between a data recovery stage and a fixed-width FIFO. In every clock cycle the recovery stage supplies a small sample bus together with a count of how many of its bits are real, anywhere from none up to a maximum of ten. The packer appends exactly those bits to an internal accumulation register. Each time a full output word has built up, it presents that word with a one-cycle valid strobe.

The bit order is kept throughout. Bit 0 of the sample bus is the oldest arriving bit, and bit 0 of each output word is the first bit that word received. Bits left over after a word has been completed stay behind and open the next word. Everything runs on one clock with a synchronous active-low reset. The output width must be at least the maximum count. Under that rule no more than one word can complete in a cycle, and the accumulator, sized to the output width plus the maximum count, can never overflow.

Top module: `vbit_packer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the accumulator is emptied, `word_vld` is cleared and `word_out` becomes zero. No bit that was received before the reset appears in any later word.
- R2: Arriving bits form a single stream. Within a cycle, `smp_in[0]` comes before `smp_in[1]` and so on, and every bit of a cycle comes after every bit of earlier cycles. Bit k of an emitted word is the k-th oldest bit that has not yet been emitted.
- R3: Only `smp_in[smp_cnt-1:0]` is taken in. Bits of `smp_in` at or above position `smp_cnt` have no effect on any output word.
- R4: `word_vld` is high in the cycle after an edge exactly when the buffered bit count plus `smp_cnt` at that edge reaches `OUT_W`, and it is low otherwise.
- R5: When a word is emitted, the bits beyond the first `OUT_W` stay in the accumulator as the start of the next word. Afterwards the buffered count equals the previous count plus `smp_cnt` minus `OUT_W`.
- R6: A cycle with `smp_cnt` = 0 adds no bits and, with fewer than `OUT_W` bits buffered, gives `word_vld` low.
- R7: `smp_cnt` never exceeds `MAX_CNT`, and `OUT_W` must be at least `MAX_CNT`, so that at most one word completes per cycle. An output width of 1 is therefore not supported.
- R8: Between edges, the accumulator holds fewer than `OUT_W` bits, and every accumulator bit at or above the buffered count is zero.
- R9: While `word_vld` is low, `word_out` keeps the last emitted word, or zero if no word has been emitted since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_in | input | MAX_CNT | Recovered bits, valid ones in the low positions, bit 0 oldest |
| smp_cnt | input | $clog2(MAX_CNT+1) | Number of valid bits on `smp_in` this cycle |
| word_out | output | OUT_W | Packed output word, bit 0 oldest |
| word_vld | output | 1 | High for one cycle per newly presented word |

## Verification
A buffered count that is off by even one bit shows at the ports when the next word is due: `word_vld` rises a cycle early or late, and every later word comes out misaligned by that offset. The first comparison against the bench's bit queue therefore catches it, at most `OUT_W` received bits after the error. Stale bits in the unused upper part of the accumulator, or high bits beyond `smp_cnt` that leak in, corrupt the very next emitted word. A long random stream whose counts run from zero to the maximum drives the leftover count through every value, so a fault that depends on a particular fill level still reaches the output.

// File: rtl/vbp_pkg.sv
// Package: shared defaults for the variable-count bit packer.
// Assumes: nothing beyond the standard language.
package vbp_pkg;
    localparam int unsigned DEF_MAX_CNT = 10;  // most bits per cycle
    localparam int unsigned DEF_OUT_W   = 16;  // packed word width
endpackage

// File: rtl/vbp_merge.sv
// Module: vbp_merge
// Masks off the invalid high bits of the sample bus and places the valid
// ones directly above the bits already buffered.
// Assumes: acc bits at and above fill are zero; cnt <= MAX_CNT.
module vbp_merge #(
    parameter int unsigned MAX_CNT = 10,
    parameter int unsigned BUF_W   = 26,
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned FILL_W  = 5
) (
    input  logic [BUF_W-1:0]   acc,
    input  logic [FILL_W-1:0]  fill,
    input  logic [MAX_CNT-1:0] smp,
    input  logic [CNT_W-1:0]   cnt,
    output logic [BUF_W-1:0]   merged,
    output logic [FILL_W-1:0]  total
);
    localparam int unsigned PAD_W = BUF_W - MAX_CNT;

    logic [MAX_CNT-1:0] kept;
    logic [BUF_W-1:0]   ext;

    // one gate per lane: pass a sample bit only when its lane is below cnt (R3)
    for (genvar i = 0; i < MAX_CNT; i++) begin : g_lane
        assign kept[i] = (CNT_W'(i) < cnt) ? smp[i] : 1'b0;
    end

    // append the kept bits on top of the buffered ones and add up the count
    always_comb begin
        ext    = {{PAD_W{1'b0}}, kept};
        merged = acc | (ext << fill);
        total  = fill + FILL_W'(cnt);
    end
endmodule

// File: rtl/vbp_split.sv
// Module: vbp_split
// Decides whether a full word is available and, if so, separates it from
// the leftover bits, which move down to position 0.
// Assumes: total < 2*OUT_W, so that at most one word completes per call.
module vbp_split #(
    parameter int unsigned OUT_W  = 16,
    parameter int unsigned BUF_W  = 26,
    parameter int unsigned FILL_W = 5
) (
    input  logic [BUF_W-1:0]  merged,
    input  logic [FILL_W-1:0] total,
    output logic              emit,
    output logic [OUT_W-1:0]  word,
    output logic [BUF_W-1:0]  rest,
    output logic [FILL_W-1:0] rest_fill
);
    // cut off a word once enough bits exist and keep the remainder (R5)
    always_comb begin
        emit      = (total >= FILL_W'(OUT_W));
        word      = merged[OUT_W-1:0];
        rest      = emit ? (merged >> OUT_W) : merged;
        rest_fill = emit ? (total - FILL_W'(OUT_W)) : total;
    end
endmodule

// File: rtl/vbit_packer.sv
// Module: vbit_packer (top)
// Collects between zero and MAX_CNT recovered bits per cycle into OUT_W-bit
// words, bit 0 oldest, with a single-cycle valid per word.
// Assumes: OUT_W >= MAX_CNT (R7), so at most one word completes per cycle;
// a single clock; synchronous active-low reset; no backpressure.
module vbit_packer
    import vbp_pkg::*;
#(
    parameter int unsigned MAX_CNT = DEF_MAX_CNT,
    parameter int unsigned OUT_W   = DEF_OUT_W,
    localparam int unsigned CNT_W  = $clog2(MAX_CNT + 1),
    localparam int unsigned BUF_W  = OUT_W + MAX_CNT,
    localparam int unsigned FILL_W = $clog2(BUF_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MAX_CNT-1:0] smp_in,
    input  logic [CNT_W-1:0]   smp_cnt,
    output logic [OUT_W-1:0]   word_out,
    output logic               word_vld
);
    logic [BUF_W-1:0]  acc_q;
    logic [FILL_W-1:0] fill_q;
    logic [BUF_W-1:0]  merged;
    logic [FILL_W-1:0] total;
    logic              emit;
    logic [OUT_W-1:0]  word;
    logic [BUF_W-1:0]  rest;
    logic [FILL_W-1:0] rest_fill;

    vbp_merge #(
        .MAX_CNT(MAX_CNT), .BUF_W(BUF_W), .CNT_W(CNT_W), .FILL_W(FILL_W)
    ) u_merge (
        .acc(acc_q), .fill(fill_q), .smp(smp_in), .cnt(smp_cnt),
        .merged(merged), .total(total)
    );

    vbp_split #(
        .OUT_W(OUT_W), .BUF_W(BUF_W), .FILL_W(FILL_W)
    ) u_split (
        .merged(merged), .total(total), .emit(emit), .word(word),
        .rest(rest), .rest_fill(rest_fill)
    );

    // accumulator state: clear on reset, otherwise take the leftover (R1, R5)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            fill_q <= '0;
        end else begin
            acc_q  <= rest;
            fill_q <= rest_fill;
        end
    end

    // output register: strobe for one cycle per word, else hold (R4, R9)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= emit;
            if (emit) word_out <= word;
        end
    end

    // R7
    cnt_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_cnt <= CNT_W'(MAX_CNT));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q < FILL_W'(OUT_W));

    // R8
    stale_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q >> fill_q) == '0);

    // R4
    vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q + FILL_W'(smp_cnt) >= FILL_W'(OUT_W)) |=> word_vld);

    // R6
    vld_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q + FILL_W'(smp_cnt) < FILL_W'(OUT_W)) |=> !word_vld);

    // R5
    carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q + FILL_W'(smp_cnt) >= FILL_W'(OUT_W)) |=>
        (fill_q == $past(fill_q) + FILL_W'($past(smp_cnt)) - FILL_W'(OUT_W)));

    // R9
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> $stable(word_out));
endmodule

// File: tb/sim_vbit_packer.sv
// Directed bench for vbit_packer: a queue of bits serves as the reference.
module sim_vbit_packer;
    localparam int unsigned MAX_CNT = 10;
    localparam int unsigned OUT_W   = 16;
    localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [MAX_CNT-1:0] smp_in = '0;
    logic [CNT_W-1:0]   smp_cnt = '0;
    logic [OUT_W-1:0]   word_out;
    logic               word_vld;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    bit          bitq[$];
    logic [OUT_W-1:0] last_word = '0;

    vbit_packer #(.MAX_CNT(MAX_CNT), .OUT_W(OUT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_cnt(smp_cnt),
        .word_out(word_out), .word_vld(word_vld)
    );

    always #5 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle of input at a falling edge, then check at the next one
    task automatic send(string req, int cnt, logic [MAX_CNT-1:0] data);
        logic             exp_vld;
        logic [OUT_W-1:0] exp_word;
        smp_in  = data;
        smp_cnt = CNT_W'(cnt);
        for (int i = 0; i < cnt; i++) bitq.push_back(data[i]);
        exp_vld  = (bitq.size() >= OUT_W);
        exp_word = last_word;
        if (exp_vld) begin
            for (int i = 0; i < OUT_W; i++) exp_word[i] = bitq.pop_front();
            last_word = exp_word;
        end
        @(negedge clk);
        check({req, " vld"}, 32'(word_vld), 32'(exp_vld));
        check({req, " word"}, 32'(word_out), 32'(exp_word));
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        smp_cnt = '0;
        smp_in  = '0;
        repeat (2) @(negedge clk);
        bitq.delete();
        last_word = '0;
        check("R1 vld after reset", 32'(word_vld), 32'd0);
        check("R1 word after reset", 32'(word_out), 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_order();
        send("R2", 10, 10'b10_1100_1011);
        send("R2", 6, 10'b00_0011_0110);
    endtask

    task automatic t_ignore_high();
        send("R3", 3, 10'b11_1111_1010);
        send("R3", 5, 10'b11_1110_0001);
        send("R3", 8, 10'b11_0101_0101);
        send("R3", 0, 10'b11_1111_1111);
    endtask

    task automatic t_zero();
        send("R6", 4, 10'h00F);
        for (int k = 0; k < 3; k++) send("R6 R9", 0, 10'h3FF);
        send("R6", 10, 10'h2A5);
        send("R4", 2, 10'h001);
    endtask

    task automatic t_carry();
        send("R5", 10, 10'h3C3);
        send("R5", 10, 10'h155);
        send("R5", 10, 10'h0F0);
        send("R5", 2, 10'h002);
    endtask

    task automatic t_exact();
        send("R4", 8, 10'h0A5);
        send("R4", 8, 10'h05A);
    endtask

    task automatic t_reset_mid();
        send("R1", 7, 10'h07F);
        do_reset();
        send("R1", 10, 10'h001);
        send("R1", 6, 10'h020);
    endtask

    task automatic t_random();
        for (int k = 0; k < 400; k++)
            send("R2 R4 R9", int'($urandom_range(0, MAX_CNT)), MAX_CNT'($urandom));
        for (int k = 0; k < 60; k++) send("R5 R8", MAX_CNT, MAX_CNT'($urandom));
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        t_order();
        t_ignore_high();
        t_zero();
        t_carry();
        t_exact();
        t_reset_mid();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule